// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller that sits on an APB bus. It has a number of pin banks set by a parameter. Each bank has an output value register and an output-enable (direction) register, and these drive the pad outputs directly. Each bank also has a read-only register that returns the external pin levels after they pass through a two-flop synchroniser.

Bank A (index 0) also carries an interrupt unit with one source per pin. For each pin, software chooses whether detection is on, whether the output is masked, whether the pin triggers on an edge or a level, and which polarity counts as active. The unit drives one interrupt line per pin and one combined line. Edge events stay latched until software writes a 1 to the matching bit of the clear register. Level events follow the synchronised pin directly.

Every APB access completes in one access cycle with no wait states and no error response.

Top module: `apb_gpio_ctrl`

## Requirements
- R1: `pready_o` is always 1 and `pslverr_o` is always 0. A read of any offset not listed in these requirements returns 0, and a write to such an offset changes no state.
- R2: For bank i, the output value register is at byte offset 0x00+0x0C*i and the output-enable register is at 0x04+0x0C*i. Each holds BANK_W bits and ignores higher write-data bits. Both read back and drive `pins_o` / `pins_oe_o` bits [i*BANK_W +: BANK_W], starting from the cycle after the write.
- R3: The read-only register at 0x50+0x04*i returns the pin levels of bank i as sampled two rising clock edges earlier. Writes to it are ignored.
- R4: The enable register is at 0x30 (1 = detect). A disabled pin shows 0 in the status register at 0x40. Clearing its enable bit discards any latched edge event.
- R5: In the type register at 0x38, a 1 bit selects edge detection. In the polarity register at 0x3C, a 1 bit selects rising and a 0 bit selects falling. A qualifying pin change is latched and appears in status on the third rising edge after the pin changes. It stays there after the pin returns to its idle level.
- R6: A type bit of 0 selects level detection. The status bit then equals the synchronised pin when the polarity bit is 1, and its inverse when the polarity bit is 0.
- R7: Writing 1 to a bit of the clear register at 0x4C clears that latched edge event. Bits written as 0 have no effect, and level-mode bits are not affected. A new edge in the same cycle as the clear wins. Reads of 0x4C return 0.
- R8: A 1 in the mask register at 0x34 forces that pin's `irq_o` bit to 0. The status bit keeps showing the pending event.
- R9: `irq_any_o` is 1 exactly when some bit of `irq_o` is 1, where `irq_o` = status AND NOT mask.
- R10: After reset every register is 0, so `pins_o`, `pins_oe_o`, `irq_o` and `irq_any_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) / read (0) |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| pins_i | input | NUM_BANKS*BANK_W | External pin levels, asynchronous |
| pins_o | output | NUM_BANKS*BANK_W | Output values to pads |
| pins_oe_o | output | NUM_BANKS*BANK_W | Output enables to pads (1 = drive) |
| irq_o | output | IRQ_W | Per-pin interrupt lines for bank A |
| irq_any_o | output | 1 | OR of all per-pin interrupt lines |

## Verification
The bench targets these corner cases:
- The exact synchroniser latency. A design with one stage too few or too many shows readback and level status a cycle early or late.
- An edge event that is still latched after the pin has returned to idle. A design that lets status follow the pin would drop the interrupt.
- A clear written in the same cycle as a fresh edge. A design where the clear wins would lose that event.
- Masking that leaves status visible, the discard of a latched event when a pin is disabled, and active-low level detection. Each of these is compared every cycle against a behavioural model, both under directed sequences and under random pin and register traffic.

// File: rtl/gpio_ctrl_pkg.sv
`timescale 1ns/1ps
package gpio_ctrl_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned OFS_OUT      = 'h00;
  localparam int unsigned OFS_DIR      = 'h04;
  localparam int unsigned BANK_STRIDE  = 'h0C;
  localparam int unsigned OFS_IRQ_EN   = 'h30;
  localparam int unsigned OFS_IRQ_MASK = 'h34;
  localparam int unsigned OFS_IRQ_TYPE = 'h38;
  localparam int unsigned OFS_IRQ_POL  = 'h3C;
  localparam int unsigned OFS_IRQ_STAT = 'h40;
  localparam int unsigned OFS_IRQ_CLR  = 'h4C;
  localparam int unsigned OFS_PIN      = 'h50;
  localparam int unsigned PIN_STRIDE   = 'h04;

  typedef enum logic [2:0] {
    IRQ_SEL_NONE,
    IRQ_SEL_EN,
    IRQ_SEL_MASK,
    IRQ_SEL_TYPE,
    IRQ_SEL_POL,
    IRQ_SEL_STAT,
    IRQ_SEL_CLR
  } irq_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] out_sel_o,
  output logic [NUM_BANKS-1:0] dir_sel_o,
  output logic [NUM_BANKS-1:0] pin_sel_o,
  output irq_sel_e             irq_sel_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign out_sel_o[b] = (addr_i == ADDR_W'(OFS_OUT + BANK_STRIDE * b));
    assign dir_sel_o[b] = (addr_i == ADDR_W'(OFS_DIR + BANK_STRIDE * b));
    assign pin_sel_o[b] = (addr_i == ADDR_W'(OFS_PIN + PIN_STRIDE * b));
  end

  always_comb begin
    irq_sel_o = IRQ_SEL_NONE;
    if (addr_i == ADDR_W'(OFS_IRQ_EN))        irq_sel_o = IRQ_SEL_EN;
    else if (addr_i == ADDR_W'(OFS_IRQ_MASK)) irq_sel_o = IRQ_SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_IRQ_TYPE)) irq_sel_o = IRQ_SEL_TYPE;
    else if (addr_i == ADDR_W'(OFS_IRQ_POL))  irq_sel_o = IRQ_SEL_POL;
    else if (addr_i == ADDR_W'(OFS_IRQ_STAT)) irq_sel_o = IRQ_SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_IRQ_CLR))  irq_sel_o = IRQ_SEL_CLR;
  end
endmodule

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_out_i,
  input  logic             wr_dir_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] dir_o
);
  logic [WIDTH-1:0] out_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_out_i) out_q <= wdata_i;
      if (wr_dir_i) dir_q <= wdata_i;
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] pin_i,
  input  logic             wr_i,
  input  irq_sel_e         sel_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] en_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] type_o,
  output logic [IRQ_W-1:0] pol_o,
  output logic [IRQ_W-1:0] status_o,
  output logic [IRQ_W-1:0] irq_o
);
  logic [IRQ_W-1:0] en_q, mask_q, type_q, pol_q;
  logic [IRQ_W-1:0] prev_q, latch_q, latch_d;
  logic [IRQ_W-1:0] rise, fall, edge_hit, clr_vec, level_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        IRQ_SEL_EN:   en_q   <= wdata_i;
        IRQ_SEL_MASK: mask_q <= wdata_i;
        IRQ_SEL_TYPE: type_q <= wdata_i;
        IRQ_SEL_POL:  pol_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rise      = pin_i & ~prev_q;
    fall      = ~pin_i & prev_q;
    edge_hit  = (pol_q & rise) | (~pol_q & fall);
    clr_vec   = (wr_i && sel_i == IRQ_SEL_CLR) ? wdata_i : '0;
    // new edge wins over a clear in the same cycle; disable or level mode drops the latch
    latch_d   = en_q & type_q & (edge_hit | (latch_q & ~clr_vec));
    level_act = ~(pin_i ^ pol_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= pin_i;
      latch_q <= latch_d;
    end
  end

  assign status_o = en_q & ((type_q & latch_q) | (~type_q & level_act));
  assign irq_o    = status_o & ~mask_q;
  assign en_o     = en_q;
  assign mask_o   = mask_q;
  assign type_o   = type_q;
  assign pol_o    = pol_q;
endmodule

// File: rtl/apb_gpio_ctrl.sv
`timescale 1ns/1ps
module apb_gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned IRQ_W     = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        psel_i,
  input  logic                        penable_i,
  input  logic                        pwrite_i,
  input  logic [ADDR_W-1:0]           paddr_i,
  input  logic [31:0]                 pwdata_i,
  output logic [31:0]                 prdata_o,
  output logic                        pready_o,
  output logic                        pslverr_o,
  input  logic [NUM_BANKS*BANK_W-1:0] pins_i,
  output logic [NUM_BANKS*BANK_W-1:0] pins_o,
  output logic [NUM_BANKS*BANK_W-1:0] pins_oe_o,
  output logic [IRQ_W-1:0]            irq_o,
  output logic                        irq_any_o
);
  localparam int unsigned PIN_W = NUM_BANKS * BANK_W;

  logic                 wr_en;
  logic [NUM_BANKS-1:0] out_sel, dir_sel, pin_sel;
  irq_sel_e             irq_sel;
  logic [PIN_W-1:0]     pins_sync;
  logic [BANK_W-1:0]    bank_out [NUM_BANKS];
  logic [BANK_W-1:0]    bank_dir [NUM_BANKS];
  logic [IRQ_W-1:0]     irq_en, irq_mask, irq_type, irq_pol, irq_stat;
  logic [31:0]          rdata;
  logic                 unused_wdata;

  assign wr_en        = psel_i & penable_i & pwrite_i;
  assign unused_wdata = ^pwdata_i[31:BANK_W];

  gpio_addr_dec #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) i_dec (
    .addr_i   (paddr_i),
    .out_sel_o(out_sel),
    .dir_sel_o(dir_sel),
    .pin_sel_o(pin_sel),
    .irq_sel_o(irq_sel)
  );

  gpio_sync2 #(.WIDTH(PIN_W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_regs #(.WIDTH(BANK_W)) i_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_out_i(wr_en & out_sel[b]),
      .wr_dir_i(wr_en & dir_sel[b]),
      .wdata_i (pwdata_i[BANK_W-1:0]),
      .out_o   (bank_out[b]),
      .dir_o   (bank_dir[b])
    );
    assign pins_o[b*BANK_W +: BANK_W]    = bank_out[b];
    assign pins_oe_o[b*BANK_W +: BANK_W] = bank_dir[b];
  end

  gpio_irq_unit #(.IRQ_W(IRQ_W)) i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pins_sync[IRQ_W-1:0]),
    .wr_i    (wr_en),
    .sel_i   (irq_sel),
    .wdata_i (pwdata_i[IRQ_W-1:0]),
    .en_o    (irq_en),
    .mask_o  (irq_mask),
    .type_o  (irq_type),
    .pol_o   (irq_pol),
    .status_o(irq_stat),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (out_sel[b]) rdata[BANK_W-1:0] = bank_out[b];
      if (dir_sel[b]) rdata[BANK_W-1:0] = bank_dir[b];
      if (pin_sel[b]) rdata[BANK_W-1:0] = pins_sync[b*BANK_W +: BANK_W];
    end
    case (irq_sel)
      IRQ_SEL_EN:   rdata[IRQ_W-1:0] = irq_en;
      IRQ_SEL_MASK: rdata[IRQ_W-1:0] = irq_mask;
      IRQ_SEL_TYPE: rdata[IRQ_W-1:0] = irq_type;
      IRQ_SEL_POL:  rdata[IRQ_W-1:0] = irq_pol;
      IRQ_SEL_STAT: rdata[IRQ_W-1:0] = irq_stat;
      default: ;
    endcase
  end

  assign prdata_o  = rdata;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
  assign irq_any_o = |irq_o;
endmodule

// File: rtl/apb_gpio_ctrl_chk.sv
`timescale 1ns/1ps
module apb_gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned IRQ_W     = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        psel_i,
  input logic                        penable_i,
  input logic                        pwrite_i,
  input logic [ADDR_W-1:0]           paddr_i,
  input logic [31:0]                 pwdata_i,
  input logic [31:0]                 prdata_o,
  input logic [NUM_BANKS*BANK_W-1:0] pins_i,
  input logic [NUM_BANKS*BANK_W-1:0] pins_o,
  input logic [IRQ_W-1:0]            irq_o,
  input logic [IRQ_W-1:0]            en_i,
  input logic [IRQ_W-1:0]            mask_i
);
  logic [1:0] live_cnt;
  logic       rd_cyc;
  logic       unused_chk;

  assign rd_cyc     = psel_i && !pwrite_i;
  assign unused_chk = ^{pwdata_i[31:BANK_W], pins_i[NUM_BANKS*BANK_W-1:BANK_W],
                        pins_o[NUM_BANKS*BANK_W-1:BANK_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (a == ADDR_W'(OFS_OUT + BANK_STRIDE * b)) hit = 1'b1;
      if (a == ADDR_W'(OFS_DIR + BANK_STRIDE * b)) hit = 1'b1;
      if (a == ADDR_W'(OFS_PIN + PIN_STRIDE * b))  hit = 1'b1;
    end
    if (a == ADDR_W'(OFS_IRQ_EN)   || a == ADDR_W'(OFS_IRQ_MASK) ||
        a == ADDR_W'(OFS_IRQ_TYPE) || a == ADDR_W'(OFS_IRQ_POL)  ||
        a == ADDR_W'(OFS_IRQ_STAT)) hit = 1'b1;
    return hit;
  endfunction

  assert_unmapped_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cyc && !is_mapped(paddr_i)) |-> (prdata_o == 32'd0));

  assert_out_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i && paddr_i == ADDR_W'(OFS_OUT))
    |=> (pins_o[BANK_W-1:0] == $past(pwdata_i[BANK_W-1:0])));

  assert_readback_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt == 2'd3 && rd_cyc && paddr_i == ADDR_W'(OFS_PIN))
    |-> (prdata_o[BANK_W-1:0] == $past(pins_i[BANK_W-1:0], 2)));

  assert_stat_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cyc && paddr_i == ADDR_W'(OFS_IRQ_STAT))
    |-> ((prdata_o & ~32'(en_i)) == 32'd0));

  assert_mask_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & mask_i) == '0));
endmodule

bind apb_gpio_ctrl apb_gpio_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .IRQ_W    (IRQ_W),
  .ADDR_W   (ADDR_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .pwdata_i (pwdata_i),
  .prdata_o (prdata_o),
  .pins_i   (pins_i),
  .pins_o   (pins_o),
  .irq_o    (irq_o),
  .en_i     (irq_en),
  .mask_i   (irq_mask)
);

// File: tb/test_apb_gpio_ctrl.sv
`timescale 1ns/1ps
module test_apb_gpio_ctrl;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int IW = 8;
  localparam int PW = NB * BW;
  localparam time T = 20ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [PW-1:0] pins = '0;
  logic [PW-1:0] pins_o, pins_oe;
  logic [IW-1:0] irq;
  logic          irq_any;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(T/2) clk_i = ~clk_i;

  apb_gpio_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .IRQ_W(IW), .ADDR_W(8)) i_apb_gpio_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .pins_i(pins), .pins_o(pins_o),
    .pins_oe_o(pins_oe), .irq_o(irq), .irq_any_o(irq_any)
  );

  function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [BW-1:0] m_out [NB];
  logic [BW-1:0] m_dir [NB];
  logic [IW-1:0] m_en, m_mask, m_typ, m_pol, m_lat;
  logic [PW-1:0] hist[$] = '{'0, '0, '0};
  logic [IW-1:0] u_s, u_p, u_eg, u_clr;
  logic [PW-1:0] e_pins, e_oe;

  function automatic logic [IW-1:0] m_status();
    logic [IW-1:0] s;
    s = hist[1][IW-1:0];
    return m_en & ((m_typ & m_lat) | (~m_typ & ~(s ^ m_pol)));
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < NB; b++) begin
      if (a == 8'(12 * b))        r = 32'(m_out[b]);
      if (a == 8'(4 + 12 * b))    r = 32'(m_dir[b]);
      if (a == 8'('h50 + 4 * b))  r = 32'(hist[1][b*BW +: BW]);
    end
    case (a)
      8'h30: r = 32'(m_en);
      8'h34: r = 32'(m_mask);
      8'h38: r = 32'(m_typ);
      8'h3C: r = 32'(m_pol);
      8'h40: r = 32'(m_status());
      default: ;
    endcase
    return r;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a >= 8'h50 && a < 8'h60 && a[1:0] == 2'b00) return "R3 readback";
    if (a == 8'h40) return "R4 status read";
    if (a < 8'h30) return "R2 bank register read";
    return "R1 register read";
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin m_out[b] = '0; m_dir[b] = '0; end
      m_en = '0; m_mask = '0; m_typ = '0; m_pol = '0; m_lat = '0;
      hist = '{'0, '0, '0};
    end else begin
      for (int b = 0; b < NB; b++) begin
        e_pins[b*BW +: BW] = m_out[b];
        e_oe[b*BW +: BW]   = m_dir[b];
      end
      chk("R2 pins_o", 32'(pins_o), 32'(e_pins));
      chk("R2 pins_oe_o", 32'(pins_oe), 32'(e_oe));
      chk("R8 irq_o", 32'(irq), 32'(m_status() & ~m_mask));
      chk("R9 irq_any_o", 32'(irq_any), 32'(|(m_status() & ~m_mask)));
      chk("R1 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
      if (psel && !pwrite) chk(rd_tag(paddr), prdata, m_read(paddr));
      // next state
      u_s  = hist[1][IW-1:0];
      u_p  = hist[2][IW-1:0];
      u_eg = (m_pol & u_s & ~u_p) | (~m_pol & ~u_s & u_p);
      u_clr = (psel && penable && pwrite && paddr == 8'h4C) ? pwdata[IW-1:0] : '0;
      m_lat = m_en & m_typ & (u_eg | (m_lat & ~u_clr));
      if (psel && penable && pwrite) begin
        for (int b = 0; b < NB; b++) begin
          if (paddr == 8'(12 * b))     m_out[b] = pwdata[BW-1:0];
          if (paddr == 8'(4 + 12 * b)) m_dir[b] = pwdata[BW-1:0];
        end
        case (paddr)
          8'h30: m_en   = pwdata[IW-1:0];
          8'h34: m_mask = pwdata[IW-1:0];
          8'h38: m_typ  = pwdata[IW-1:0];
          8'h3C: m_pol  = pwdata[IW-1:0];
          default: ;
        endcase
      end
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk_i); penable = 1;
    @(negedge clk_i); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk_i); penable = 1;
    #(T/4) d = prdata;
    @(negedge clk_i); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] alist [12];
    alist = '{8'h00, 8'h04, 8'h18, 8'h28, 8'h30, 8'h34, 8'h38, 8'h3C,
              8'h4C, 8'h4C, 8'h40, 8'h08};
    idle(3);
    rst_ni = 1;
    idle(1);
    // R10 reset state
    chk("R10 pins_o after reset", 32'(pins_o), 0);
    chk("R10 pins_oe_o after reset", 32'(pins_oe), 0);
    chk("R10 irq after reset", {31'(irq), irq_any}, 0);
    rd(8'h30, d); chk("R10 enable reg after reset", d, 0);

    // R2 bank registers
    wr(8'h00, 32'h0000_00A5);
    rd(8'h00, d); chk("R2 bank0 out readback", d, 32'hA5);
    chk("R2 bank0 pins_o", 32'(pins_o[7:0]), 32'hA5);
    wr(8'h1C, 32'h3C);
    chk("R2 bank2 dir drives pins_oe_o", 32'(pins_oe[23:16]), 32'h3C);
    wr(8'h24, 32'hFF);
    chk("R2 bank3 out", 32'(pins_o[31:24]), 32'hFF);
    rd(8'h28, d); chk("R2 bank3 dir untouched", d, 0);
    wr(8'h00, 32'hFFFF_FF5A);
    rd(8'h00, d); chk("R2 upper write bits ignored", d, 32'h5A);

    // R1 unmapped
    rd(8'h08, d); chk("R1 unmapped 0x08 reads zero", d, 0);
    rd(8'h44, d); chk("R1 unmapped 0x44 reads zero", d, 0);
    rd(8'h60, d); chk("R1 unmapped 0x60 reads zero", d, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R1 unmapped write leaves outputs", 32'(pins_o), 32'hFF00_005A);

    // R3 readback latency and read-only
    pins[15:8] = 8'h96;
    idle(3);
    rd(8'h54, d); chk("R3 bank1 readback", d, 32'h96);
    wr(8'h54, 32'h0);
    rd(8'h54, d); chk("R3 readback write ignored", d, 32'h96);
    psel = 1; pwrite = 0; paddr = 8'h58; pins[23:16] = 8'h11;
    @(posedge clk_i); #(T/4);
    chk("R3 one edge: not yet visible", prdata, 0);
    @(posedge clk_i); #(T/4);
    chk("R3 two edges: visible", prdata, 32'h11);
    @(negedge clk_i); psel = 0;

    // R5 edge detection
    wr(8'h38, 32'h13);
    wr(8'h3C, 32'h15);
    wr(8'h30, 32'h01);
    pins[0] = 1; idle(4);
    chk("R5 rising edge latched", 32'(irq), 32'h01);
    chk("R9 combined line", 32'(irq_any), 1);
    rd(8'h40, d); chk("R5 status shows edge", d, 32'h01);
    pins[0] = 0; idle(4);
    chk("R5 edge held after pin idle", 32'(irq), 32'h01);
    wr(8'h4C, 32'h00);
    chk("R7 zero clear bits no effect", 32'(irq), 32'h01);
    rd(8'h4C, d); chk("R7 clear reg reads zero", d, 0);
    wr(8'h4C, 32'h01);
    chk("R7 clear removes edge", 32'(irq), 0);
    wr(8'h30, 32'h03);
    pins[1] = 1; idle(4);
    chk("R5 falling mode ignores rise", 32'(irq), 0);
    pins[1] = 0; idle(4);
    chk("R5 falling edge latched", 32'(irq), 32'h02);

    // R8 mask
    wr(8'h34, 32'h02);
    chk("R8 masked line low", 32'(irq), 0);
    chk("R9 combined low when masked", 32'(irq_any), 0);
    rd(8'h40, d); chk("R8 status still pending", d, 32'h02);
    wr(8'h34, 32'h00);
    chk("R8 unmask restores", 32'(irq), 32'h02);
    wr(8'h4C, 32'h02);

    // R6 level
    wr(8'h30, 32'h07);
    pins[2] = 1; idle(3);
    chk("R6 active-high level", 32'(irq), 32'h04);
    wr(8'h4C, 32'h04);
    chk("R7 clear ignored for level", 32'(irq), 32'h04);
    pins[2] = 0; idle(3);
    chk("R6 level follows pin", 32'(irq), 0);
    wr(8'h30, 32'h0F);
    chk("R6 active-low level asserts", 32'(irq), 32'h08);
    pins[3] = 1; idle(3);
    chk("R6 active-low released", 32'(irq), 0);

    // R4 disable discards
    pins[0] = 1; idle(4);
    chk("R4 edge pending before disable", 32'(irq), 32'h01);
    wr(8'h30, 32'h0E);
    chk("R4 disabled pin quiet", 32'(irq), 0);
    rd(8'h40, d); chk("R4 status zero when disabled", d, 0);
    wr(8'h30, 32'h0F);
    chk("R4 latch discarded on re-enable", 32'(irq), 0);

    // R7 set wins over same-cycle clear
    wr(8'h30, 32'h1F);
    pins[4] = 1; idle(4);
    chk("R5 pin4 rising latched", 32'(irq), 32'h10);
    pins[4] = 0; idle(4);
    pins[4] = 1; idle(1);
    wr(8'h4C, 32'h10);
    chk("R7 new edge wins over clear", 32'(irq), 32'h10);
    wr(8'h4C, 32'h10);
    chk("R7 later clear removes", 32'(irq), 0);

    // random traffic against the model
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 2) == 0) pins = $urandom;
      if ($urandom_range(0, 1) == 0)
        wr(alist[$urandom_range(0, 11)], $urandom);
      else begin
        rd(alist[$urandom_range(0, 11)], d);
        rd(8'(8'h50 + 4 * $urandom_range(0, 3)), d);
      end
    end
    idle(4);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule